// File: doc/BRIEF.md
# Register Scoreboard Issue Interlock

This block is the hazard gate at the issue stage of an in-order pipeline with a small register file. For every register it holds one bit that says whether that register's value can be read now. Each cycle it looks at the instruction at the head of the issue queue and decides whether that instruction may issue. If it may not, the block raises a stall, and every younger instruction waits behind the head.

An instruction may issue when every register it reads is ready and its destination is also ready. Checking the destination prevents two writes in flight to the same register. When an instruction issues, its destination is marked stale. When a functional unit reports completion on one of the completion ports, the destination it names becomes ready again. A completion that arrives in the same cycle as the check already counts, through bypass, so the stall clears in the cycle the result appears. Register 0 always reads as ready.

Top module: `reg_scoreboard_issue`

## Requirements
- R1: After reset every register is ready, so a head instruction that reads and writes any registers is granted at once.
- R2: A head instruction that uses a source register marked stale, with no completion for that register in the same cycle, is not granted.
- R3: A granted instruction whose destination-use flag is set marks its destination stale from the next cycle on.
- R4: A completion port with its valid bit set marks the named register ready from the next cycle on.
- R5: A head instruction whose used destination is stale is not granted, even when all its sources are ready (write-after-write).
- R6: Issue is in order. `stall` is high exactly when `head_vld` is high and `issue_go` is low, and both outputs are low when `head_vld` is low.
- R7: A completion on either port in the current cycle satisfies a source or destination check on that register in the same cycle.
- R8: If a grant and a completion name the same register in one cycle, the register ends up stale.
- R9: Register 0 is always ready. Writing it never makes it stale.
- R10: A source or destination whose use flag is low plays no part in the grant decision and changes no register's state.
- R11: Both completion ports may be active in the same cycle for different registers, and both registers become ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| head_vld | input | 1 | An instruction is present at the queue head |
| head_src | input | NUM_SRC*IDX_W | Source register indices; operand k sits at bits [k*IDX_W +: IDX_W] |
| head_src_use | input | NUM_SRC | Bit k set when operand k is actually read |
| head_dst | input | IDX_W | Destination register index |
| head_dst_use | input | 1 | The head instruction writes a register |
| cmp_vld | input | NUM_CMP | Bit k set when completion port k delivers a result |
| cmp_dst | input | NUM_CMP*IDX_W | Destination index of port k at bits [k*IDX_W +: IDX_W] |
| issue_go | output | 1 | Head instruction issues this cycle |
| stall | output | 1 | Head instruction is present but held |

## Verification
A grant and a completion can fall in the same cycle. The bench provokes this by pointing a completion port at the stale register that the head instruction both reads and writes. It then judges two things: the bypass, by seeing the grant in that very cycle, and the ordering between clear and set, by seeing a later reader of that register stall with no completion present. The same cycle-sharing occurs when two completions arrive together, and that case is judged by a grant in the following cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
   // Default geometry of the scoreboard
   localparam int SB_DEF_REGS = 8;
   localparam int SB_DEF_SRC  = 2;
   localparam int SB_DEF_CMP  = 2;

   // Meaning of one scoreboard bit
   typedef enum logic {
      SB_STALE = 1'b0,
      SB_READY = 1'b1
   } sb_state_e;
endpackage

// File: rtl/sb_valid_array.sv
// Holds one readiness bit per register; issue clear beats completion set.
module sb_valid_array #(
   parameter int NUM_REGS   = sb_pkg::SB_DEF_REGS,
   parameter int NUM_CMP    = sb_pkg::SB_DEF_CMP,
   parameter bit ZERO_FIXED = 1'b1,
   localparam int IDX_W     = $clog2(NUM_REGS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_en,
   input  logic [IDX_W-1:0]         clr_idx,
   input  logic [NUM_CMP-1:0]       cmp_vld,
   input  logic [NUM_CMP*IDX_W-1:0] cmp_dst,
   output logic [NUM_REGS-1:0]      vbits
);
   import sb_pkg::*;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      if (ZERO_FIXED && r == 0) begin : g_fixed
         assign vbits[r] = SB_READY;
      end else begin : g_flop
         logic set_hit;
         logic clr_hit;
         always_comb begin
            set_hit = 1'b0;
            for (int k = 0; k < NUM_CMP; k++) begin
               if (cmp_vld[k] && (cmp_dst[k*IDX_W +: IDX_W] == IDX_W'(r)))
                  set_hit = 1'b1;
            end
         end
         assign clr_hit = clr_en && (clr_idx == IDX_W'(r));
         always_ff @(posedge clk) begin
            if (!rst_n)       vbits[r] <= SB_READY;
            else if (clr_hit) vbits[r] <= SB_STALE;
            else if (set_hit) vbits[r] <= SB_READY;
         end
      end
   end
endmodule

// File: rtl/sb_avail.sv
// Combines stored readiness with same-cycle completions (bypass).
module sb_avail #(
   parameter int NUM_REGS = sb_pkg::SB_DEF_REGS,
   parameter int NUM_CMP  = sb_pkg::SB_DEF_CMP,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0]      vbits,
   input  logic [NUM_CMP-1:0]       cmp_vld,
   input  logic [NUM_CMP*IDX_W-1:0] cmp_dst,
   output logic [NUM_REGS-1:0]      avail
);
   logic [NUM_REGS-1:0] byp;

   always_comb begin
      byp = '0;
      for (int k = 0; k < NUM_CMP; k++) begin
         if (cmp_vld[k]) byp[cmp_dst[k*IDX_W +: IDX_W]] = 1'b1;
      end
   end

   assign avail = vbits | byp;
endmodule

// File: rtl/sb_operand_check.sv
// One operand lookup: passes when unused or when its register is available.
module sb_operand_check #(
   parameter int NUM_REGS = sb_pkg::SB_DEF_REGS,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0] avail,
   input  logic [IDX_W-1:0]    idx,
   input  logic                use_en,
   output logic                ok
);
   assign ok = !use_en || avail[idx];
endmodule

// File: rtl/reg_scoreboard_issue.sv
module reg_scoreboard_issue #(
   parameter int NUM_REGS   = sb_pkg::SB_DEF_REGS,
   parameter int NUM_SRC    = sb_pkg::SB_DEF_SRC,
   parameter int NUM_CMP    = sb_pkg::SB_DEF_CMP,
   parameter bit ZERO_FIXED = 1'b1,
   localparam int IDX_W     = $clog2(NUM_REGS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     head_vld,
   input  logic [NUM_SRC*IDX_W-1:0] head_src,
   input  logic [NUM_SRC-1:0]       head_src_use,
   input  logic [IDX_W-1:0]         head_dst,
   input  logic                     head_dst_use,
   input  logic [NUM_CMP-1:0]       cmp_vld,
   input  logic [NUM_CMP*IDX_W-1:0] cmp_dst,
   output logic                     issue_go,
   output logic                     stall
);
   localparam int NUM_OPS = NUM_SRC + 1;

   // Elaboration-time parameter checks
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("NUM_REGS must be a power of two and at least 2");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("NUM_SRC must be at least 1");
   end
   if (NUM_CMP < 1) begin : g_bad_cmp
      $error("NUM_CMP must be at least 1");
   end

   logic [NUM_REGS-1:0] vbits;
   logic [NUM_REGS-1:0] avail;
   logic [NUM_OPS-1:0]  op_ok;
   logic                grant;

   sb_avail #(.NUM_REGS(NUM_REGS), .NUM_CMP(NUM_CMP)) u_avail (
      .vbits   (vbits),
      .cmp_vld (cmp_vld),
      .cmp_dst (cmp_dst),
      .avail   (avail)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      sb_operand_check #(.NUM_REGS(NUM_REGS)) u_chk (
         .avail  (avail),
         .idx    (head_src[s*IDX_W +: IDX_W]),
         .use_en (head_src_use[s]),
         .ok     (op_ok[s])
      );
   end

   // Destination check guards against write-after-write
   sb_operand_check #(.NUM_REGS(NUM_REGS)) u_dst_chk (
      .avail  (avail),
      .idx    (head_dst),
      .use_en (head_dst_use),
      .ok     (op_ok[NUM_SRC])
   );

   assign grant    = head_vld && (&op_ok);
   assign issue_go = grant;
   assign stall    = head_vld && !grant;

   sb_valid_array #(
      .NUM_REGS   (NUM_REGS),
      .NUM_CMP    (NUM_CMP),
      .ZERO_FIXED (ZERO_FIXED)
   ) u_vbits (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_en  (grant && head_dst_use),
      .clr_idx (head_dst),
      .cmp_vld (cmp_vld),
      .cmp_dst (cmp_dst),
      .vbits   (vbits)
   );
endmodule

// File: rtl/sb_issue_chk.sv
module sb_issue_chk #(
   parameter int NUM_REGS   = 8,
   parameter int NUM_CMP    = 2,
   parameter bit ZERO_FIXED = 1'b1,
   localparam int IDX_W     = $clog2(NUM_REGS)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     head_vld,
   input logic [IDX_W-1:0]         head_dst,
   input logic                     head_dst_use,
   input logic [NUM_CMP-1:0]       cmp_vld,
   input logic [NUM_CMP*IDX_W-1:0] cmp_dst,
   input logic                     issue_go,
   input logic                     stall,
   input logic [NUM_REGS-1:0]      vbits
);
   // R3 and R8: a granted write leaves its target stale, whatever completes
   a_r3_issue_marks_stale: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_go && head_dst_use && (!ZERO_FIXED || head_dst != '0))
      |=> !vbits[$past(head_dst)]);

   // R4: completion sets the register unless a grant clears it
   for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
      a_r4_cmp_marks_ready: assert property (@(posedge clk) disable iff (!rst_n)
         (cmp_vld[k] && !(issue_go && head_dst_use &&
            head_dst == cmp_dst[k*IDX_W +: IDX_W]))
         |=> vbits[$past(cmp_dst[k*IDX_W +: IDX_W])]);
   end

   // R6: grant and stall split a present head and are silent without one
   a_r6_stall_xor_grant: assert property (@(posedge clk) disable iff (!rst_n)
      head_vld |-> (issue_go != stall));
   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !head_vld |-> !(issue_go || stall));

   // R9: register 0 stays ready across a write to it
   a_r9_zero_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_FIXED && issue_go && head_dst_use && head_dst == '0) |=> vbits[0]);
endmodule

bind reg_scoreboard_issue sb_issue_chk #(
   .NUM_REGS   (NUM_REGS),
   .NUM_CMP    (NUM_CMP),
   .ZERO_FIXED (ZERO_FIXED)
) u_sb_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .head_vld     (head_vld),
   .head_dst     (head_dst),
   .head_dst_use (head_dst_use),
   .cmp_vld      (cmp_vld),
   .cmp_dst      (cmp_dst),
   .issue_go     (issue_go),
   .stall        (stall),
   .vbits        (vbits)
);

// File: tb/sim_reg_scoreboard_issue.sv
module sim_reg_scoreboard_issue;
   localparam int NREGS = 8;
   localparam int IW    = 3;
   localparam int NROWS = 18;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          head_vld;
   logic [2*IW-1:0] head_src;
   logic [1:0]    head_src_use;
   logic [IW-1:0] head_dst;
   logic          head_dst_use;
   logic [1:0]    cmp_vld;
   logic [2*IW-1:0] cmp_dst;
   logic          issue_go;
   logic          stall;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   reg_scoreboard_issue #(.NUM_REGS(NREGS), .NUM_SRC(2), .NUM_CMP(2)) u0 (
      .clk, .rst_n, .head_vld, .head_src, .head_src_use, .head_dst,
      .head_dst_use, .cmp_vld, .cmp_dst, .issue_go, .stall
   );

   // Row: vld, srcA, useA, srcB, useB, dst, useD, c0v, c0d, c1v, c1d, expected grant
   function automatic logic [21:0] row(input logic v, input logic [2:0] sa, input logic ua,
      input logic [2:0] sb, input logic ub, input logic [2:0] d, input logic ud,
      input logic c0v, input logic [2:0] c0d, input logic c1v, input logic [2:0] c1d,
      input logic go);
      return {v, sa, ua, sb, ub, d, ud, c0v, c0d, c1v, c1d, go};
   endfunction

   localparam logic [21:0] VEC [NROWS] = '{
      row(1,2,1,2,1,3,1, 0,0,0,0, 1), // 0  R1 all ready; r3 goes stale (R3)
      row(1,2,1,5,1,4,1, 0,0,0,0, 1), // 1  r4 goes stale
      row(1,6,1,3,1,3,1, 0,0,0,0, 0), // 2  R2 reads stale r3
      row(1,6,1,3,1,3,1, 1,3,0,0, 1), // 3  R7 port 0 bypass of r3
      row(1,3,1,1,1,5,1, 0,0,0,0, 0), // 4  R8 r3 still stale after clear-vs-set
      row(1,3,1,1,1,5,1, 0,0,1,3, 1), // 5  R7 port 1 bypass
      row(1,4,1,7,1,4,1, 0,0,0,0, 0), // 6  R2 reads stale r4
      row(1,1,1,2,1,5,1, 0,0,0,0, 0), // 7  R5 destination r5 stale
      row(0,0,0,0,0,0,0, 1,5,1,4, 0), // 8  R11 two completions, idle head (R6)
      row(1,4,1,5,1,4,1, 0,0,0,0, 1), // 9  R4 R11 both now ready
      row(1,1,1,1,1,0,1, 0,0,0,0, 1), // 10 R9 write to r0
      row(1,0,1,0,1,1,1, 0,0,0,0, 1), // 11 R9 r0 still ready
      row(1,1,0,1,0,2,1, 0,0,0,0, 1), // 12 R10 unused stale sources
      row(1,1,1,1,1,6,1, 0,0,1,1, 1), // 13 R7 bypass r1 on port 1
      row(1,1,1,1,1,7,1, 0,0,0,0, 1), // 14 R4 r1 ready after completion
      row(1,6,1,6,1,1,1, 0,0,0,0, 0), // 15 R6 head blocked
      row(1,1,1,1,1,4,0, 0,0,0,0, 1), // 16 R10 unused stale destination
      row(1,4,1,4,1,2,0, 0,0,0,0, 0)  // 17 R10 r4 untouched by unused write
   };

   function automatic string tag_of(input int i);
      case (i)
         0: return "R1";   1: return "R3";   2: return "R2";   3: return "R7";
         4: return "R8";   5: return "R7";   6: return "R2";   7: return "R5";
         8: return "R11";  9: return "R4";   10: return "R9";  11: return "R9";
         12: return "R10"; 13: return "R7";  14: return "R4";  15: return "R6";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic [21:0] r);
      head_vld     = r[21];
      head_src     = {r[16:14], r[20:18]};
      head_src_use = {r[13], r[17]};
      head_dst     = r[12:10];
      head_dst_use = r[9];
      cmp_vld      = {r[4], r[8]};
      cmp_dst      = {r[3:1], r[7:5]};
   endtask

   initial begin
      rst_n = 1'b0;
      drive('0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #5;
      check("R6", issue_go, 1'b0, "grant idle after reset");
      check("R6", stall, 1'b0, "stall idle after reset");

      for (int i = 0; i < NROWS; i++) begin
         @(negedge clk);
         drive(VEC[i]);
         #5;
         check(tag_of(i), issue_go, VEC[i][0], $sformatf("grant row %0d", i));
         check(tag_of(i), stall, VEC[i][21] & ~VEC[i][0], $sformatf("stall row %0d", i));
      end

      // R1: reset returns every stale register to ready
      @(negedge clk);
      drive('0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      drive(row(1,2,1,4,1,6,1, 0,0,0,0, 1));
      #5;
      check("R1", issue_go, 1'b1, "grant on stale set after reset");
      @(negedge clk);
      drive(row(1,7,1,1,1,4,1, 0,0,0,0, 1));
      #5;
      check("R1", issue_go, 1'b1, "second grant after reset");
      @(negedge clk);
      drive(row(1,6,1,0,0,5,1, 0,0,0,0, 0));
      #5;
      check("R3", issue_go, 1'b0, "r6 stale after fresh grant");
      check("R6", stall, 1'b1, "stall on stale r6");
      @(negedge clk);
      drive('0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule